// File: doc/BRIEF.md
# Parallel ATA Register Access Engine

This host-side engine runs one register access at a time on a parallel ATA (IDE) bus. A request names the register through a block select and a 3-bit address. The block select picks between the command block and the control block. The request also gives a direction, a wide flag and write data. The engine then drives the active-low chip selects, the address lines, the active-low read and write strobes, and the output enable of the shared 16-bit data bus. It returns the read data together with a one-cycle completion pulse.

Each access follows a fixed order. First the data bus is turned to the right direction. Next the register select is presented and held for a programmable number of setup cycles. The strobe is then held low for a programmable number of cycles. A final release cycle follows. Only the data register (command block, address 000) can move 16 bits. Every other register is an 8-bit access, whatever the wide flag says. Command sequencing, interrupts and DMA belong to the software or logic above the engine.

Top module: `ata_reg_engine`

## Requirements
- R1: After reset, and whenever no access is in progress, both chip selects and both strobes are high, the output enable is low, the address lines and the driven data are zero, and `req_ready` is high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` seen while an access is in progress is dropped and changes no bus pin.
- R3: A read spends the cycle after acceptance with the bus released (output enable low) and the chip selects still high. It then presents the select, then holds `ata_rd_n` low, then has one release cycle with both strobes high and the select still driven. The output enable stays low for the whole read.
- R4: A write raises the output enable and drives the data from the cycle after acceptance through the release cycle. It then drops the output enable in the first idle cycle after the release cycle, one cycle after `ata_wr_n` goes back high.
- R5: The select is held for max(`cfg_setup`,1) cycles before the strobe falls.
- R6: The strobe stays low for max(`cfg_strobe`,1) cycles.
- R7: The two timing counts are captured when a request is accepted. Changing them during an access leaves that access unchanged.
- R8: `req_ctrl_blk`=0 (command block) drives `ata_cs0_n`=0 and `ata_cs1_n`=1. `req_ctrl_blk`=1 (control block) drives `ata_cs0_n`=1 and `ata_cs1_n`=0. `ata_addr` carries `req_addr` while a chip select is low and reads 000 otherwise.
- R9: Read data is the value on `ata_din` during the last strobe-low cycle. It appears on `rsp_rdata` with the one-cycle `rsp_done` pulse in the release cycle. Writes also pulse `rsp_done` in their release cycle.
- R10: An access is 16 bits wide only when `req_wide`=1, `req_ctrl_blk`=0 and `req_addr`=000. Every other access is 8 bits wide.
- R11: An 8-bit read returns bits 15..8 as zero. An 8-bit write drives bits 15..8 as zero. A 16-bit access carries all 16 bits both ways.
- R12: The read and write strobes are never low together, and a strobe is low only while exactly one chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ctrl_blk | input | 1 | 0 = command block, 1 = control block |
| req_addr | input | 3 | Register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Ask for a 16-bit transfer |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | TW (4) | Setup cycles before the strobe |
| cfg_strobe | input | TW (4) | Strobe-low cycles |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done on reads |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_addr | output | 3 | Register address lines |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Data driven toward the bus |
| ata_doe | output | 1 | Data bus output enable |
| ata_din | input | 16 | Data from the bus |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is still in progress. Close to it is a timing setting that changes during an access. Neither case shows an effect unless the bench knows exactly which cycle each pin moves in. The stimulus therefore pulses `req_valid` with different data in the middle of an access, and rewrites both timing counts right after a request is taken. The reference model keeps predicting from the values it captured at acceptance. The bus input changes every cycle, so a read sampled one cycle early or late returns a wrong value.

// File: rtl/ata_pkg.sv
package ata_pkg;
    localparam int DW   = 16;
    localparam int HALF = DW / 2;
    localparam int AW   = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_STROBE,
        PH_REL
    } phase_e;

    typedef struct packed {
        logic          ctrl_blk;
        logic [AW-1:0] addr;
        logic          write;
        logic          wide;
        logic [DW-1:0] wdata;
    } acc_t;

    typedef struct packed {
        logic cs0_n;
        logic cs1_n;
    } cs_t;

    // 16-bit lanes exist only for the command-block data register
    function automatic logic eff_wide(logic ctrl, logic [AW-1:0] a, logic w);
        return w && !ctrl && (a == '0);
    endfunction

    function automatic cs_t cs_encode(logic ctrl);
        cs_t c;
        c.cs0_n = ctrl;
        c.cs1_n = !ctrl;
        return c;
    endfunction

    function automatic logic [DW-1:0] lane_mask(logic wide, logic [DW-1:0] d);
        return wide ? d : {{HALF{1'b0}}, d[HALF-1:0]};
    endfunction
endpackage

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ata_seq.sv
module ata_seq
    import ata_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  acc_t          req_acc,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_strobe,
    output logic          req_ready,
    output acc_t          cur_acc,
    output logic          sample_now,
    output logic          rel_now,
    output logic          cs0_n,
    output logic          cs1_n,
    output logic [AW-1:0] addr,
    output logic          rd_n,
    output logic          wr_n,
    output logic          doe,
    output logic [DW-1:0] dout
);
    phase_e        phase;
    logic [TW-1:0] setup_m1, strobe_m1;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          req_wide_eff;
    logic          selected;
    cs_t           cs_act;

    always_comb req_wide_eff = eff_wide(req_acc.ctrl_blk, req_acc.addr, req_acc.wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cur_acc   <= '0;
            setup_m1  <= '0;
            strobe_m1 <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req_valid) begin
                    phase            <= PH_TURN;
                    cur_acc.ctrl_blk <= req_acc.ctrl_blk;
                    cur_acc.addr     <= req_acc.addr;
                    cur_acc.write    <= req_acc.write;
                    cur_acc.wide     <= req_wide_eff;
                    cur_acc.wdata    <= lane_mask(req_wide_eff, req_acc.wdata);
                    setup_m1  <= (cfg_setup  == '0) ? '0 : cfg_setup  - 1'b1;
                    strobe_m1 <= (cfg_strobe == '0) ? '0 : cfg_strobe - 1'b1;
                end
                PH_TURN:   phase <= PH_SETUP;
                PH_SETUP:  if (tmr_done) phase <= PH_STROBE;
                PH_STROBE: if (tmr_done) phase <= PH_REL;
                PH_REL:    phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        tmr_load = (phase == PH_TURN) || (phase == PH_SETUP && tmr_done);
        tmr_val  = (phase == PH_TURN) ? setup_m1 : strobe_m1;
    end

    ata_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_comb begin
        selected   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_REL);
        cs_act     = selected ? cs_encode(cur_acc.ctrl_blk) : '{cs0_n: 1'b1, cs1_n: 1'b1};
        cs0_n      = cs_act.cs0_n;
        cs1_n      = cs_act.cs1_n;
        addr       = selected ? cur_acc.addr : '0;
        rd_n       = !(phase == PH_STROBE && !cur_acc.write);
        wr_n       = !(phase == PH_STROBE &&  cur_acc.write);
        doe        = cur_acc.write && (phase != PH_IDLE);
        dout       = doe ? cur_acc.wdata : '0;
        req_ready  = (phase == PH_IDLE);
        rel_now    = (phase == PH_REL);
        sample_now = (phase == PH_STROBE) && tmr_done && !cur_acc.write;
    end

    assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> wr_n);
    assert_strobe_selected_R12: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (cs0_n != cs1_n));
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cs0_n && cs1_n && rd_n && wr_n && !doe));
    assert_read_bus_free_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !doe);
    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> doe);
    assert_setup_first_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(cs0_n != cs1_n));
endmodule

// File: rtl/ata_rd_capture.sv
module ata_rd_capture
    import ata_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic          wide,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (sample)
            rdata <= lane_mask(wide, din);
    end
endmodule

// File: rtl/ata_reg_engine.sv
module ata_reg_engine
    import ata_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_ctrl_blk,
    input  logic [2:0]    req_addr,
    input  logic          req_write,
    input  logic          req_wide,
    input  logic [15:0]   req_wdata,
    input  logic [TW-1:0] cfg_setup,
    input  logic [TW-1:0] cfg_strobe,
    output logic          rsp_done,
    output logic [15:0]   rsp_rdata,
    output logic          ata_cs0_n,
    output logic          ata_cs1_n,
    output logic [2:0]    ata_addr,
    output logic          ata_rd_n,
    output logic          ata_wr_n,
    output logic [15:0]   ata_dout,
    output logic          ata_doe,
    input  logic [15:0]   ata_din
);
    acc_t req_acc, cur_acc;
    logic sample_now;

    always_comb begin
        req_acc.ctrl_blk = req_ctrl_blk;
        req_acc.addr     = req_addr;
        req_acc.write    = req_write;
        req_acc.wide     = req_wide;
        req_acc.wdata    = req_wdata;
    end

    ata_seq #(.TW(TW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_acc    (req_acc),
        .cfg_setup  (cfg_setup),
        .cfg_strobe (cfg_strobe),
        .req_ready  (req_ready),
        .cur_acc    (cur_acc),
        .sample_now (sample_now),
        .rel_now    (rsp_done),
        .cs0_n      (ata_cs0_n),
        .cs1_n      (ata_cs1_n),
        .addr       (ata_addr),
        .rd_n       (ata_rd_n),
        .wr_n       (ata_wr_n),
        .doe        (ata_doe),
        .dout       (ata_dout)
    );

    ata_rd_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .sample (sample_now),
        .wide   (cur_acc.wide),
        .din    (ata_din),
        .rdata  (rsp_rdata)
    );

    assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(!ata_rd_n || !ata_wr_n));
    assert_narrow_upper_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !cur_acc.write && !cur_acc.wide) |-> (rsp_rdata[15:8] == 8'h00));
endmodule

// File: tb/ata_reg_engine_tb.sv
`timescale 1ns/1ps
module ata_reg_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ctrl_blk = 1'b0;
    logic [2:0]  req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_setup = 4'd1;
    logic [3:0]  cfg_strobe = 4'd1;
    logic [15:0] ata_din = '0;
    logic        req_ready, rsp_done, ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n, ata_doe;
    logic [15:0] rsp_rdata, ata_dout;
    logic [2:0]  ata_addr;

    always #2 clk = ~clk;

    ata_reg_engine #(.TW(4)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctrl_blk(req_ctrl_blk), .req_addr(req_addr), .req_write(req_write),
        .req_wide(req_wide), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_addr(ata_addr),
        .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dout(ata_dout),
        .ata_doe(ata_doe), .ata_din(ata_din)
    );

    typedef struct {
        bit        idle;
        bit        cs0n, cs1n;
        bit [2:0]  addr;
        bit        rdn, wrn, doe;
        bit [15:0] dout;
        bit        done, rd, wide, sample;
    } exp_t;

    exp_t      q[$];
    int        vectors = 0;
    int        fails = 0;
    bit        finished = 0;
    bit [15:0] pat = 16'hACE1;
    bit [15:0] exp_rd = '0;
    string     scen = "R1 reset";

    task automatic chk(string tag, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] act=%0h exp=%0h at %0t", tag, scen, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // one clock: compare this cycle's outputs against the model, then change the bus input
    task automatic step(output bit was_idle);
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else begin
            e = '{idle: 1, cs0n: 1, cs1n: 1, addr: 0, rdn: 1, wrn: 1, doe: 0,
                  dout: 0, done: 0, rd: 0, wide: 0, sample: 0};
        end
        vectors++;
        chk("R2 ready",  req_ready, e.idle);
        chk("R1 R8 cs0", ata_cs0_n, e.cs0n);
        chk("R1 R8 cs1", ata_cs1_n, e.cs1n);
        chk("R8 addr",   ata_addr,  e.addr);
        chk("R3 R5 R6 R12 rd_n", ata_rd_n, e.rdn);
        chk("R4 R5 R6 R12 wr_n", ata_wr_n, e.wrn);
        chk("R3 R4 doe", ata_doe,   e.doe);
        chk("R10 R11 dout", ata_dout, e.dout);
        chk("R9 done",   rsp_done,  e.done);
        if (e.done && e.rd) chk("R9 R10 R11 rdata", rsp_rdata, exp_rd);
        pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
        ata_din = pat;
        if (e.sample) exp_rd = e.wide ? pat : {8'h00, pat[7:0]};
        was_idle = e.idle;
    endtask

    task automatic push_model(bit blk, bit [2:0] a, bit wr, bit wide, bit [15:0] wd,
                              int su, int st);
        exp_t e;
        bit   w = wide && !blk && (a == 0);
        int   s = (su == 0) ? 1 : su;
        int   t = (st == 0) ? 1 : st;
        bit [15:0] d = w ? wd : {8'h00, wd[7:0]};
        e = '{idle: 0, cs0n: 1, cs1n: 1, addr: 0, rdn: 1, wrn: 1, doe: wr,
              dout: wr ? d : 16'h0, done: 0, rd: !wr, wide: w, sample: 0};
        q.push_back(e);
        e.cs0n = blk; e.cs1n = !blk; e.addr = a;
        for (int i = 0; i < s; i++) q.push_back(e);
        for (int i = 0; i < t; i++) begin
            e.rdn = wr; e.wrn = !wr; e.sample = (i == t - 1) && !wr;
            q.push_back(e);
        end
        e.rdn = 1; e.wrn = 1; e.sample = 0; e.done = 1;
        q.push_back(e);
    endtask

    task automatic access(string tag, bit blk, bit [2:0] a, bit wr, bit wide,
                          bit [15:0] wd, int su, int st, bit disturb);
        bit idle = 0;
        while (!idle) step(idle);
        scen = tag;
        req_valid = 1; req_ctrl_blk = blk; req_addr = a; req_write = wr;
        req_wide = wide; req_wdata = wd; cfg_setup = su[3:0]; cfg_strobe = st[3:0];
        push_model(blk, a, wr, wide, wd, su, st);
        step(idle);
        req_valid = 0;
        if (disturb) begin
            // R7: counts changed mid-access; R2: a request while busy
            cfg_setup = 4'd9; cfg_strobe = 4'd11;
            step(idle);
            req_valid = 1; req_ctrl_blk = !blk; req_addr = ~a; req_write = !wr;
            req_wdata = ~wd;
            step(idle);
            req_valid = 0;
        end
    endtask

    initial begin
        bit idle;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        repeat (2) step(idle);
        access("R4 R8 narrow cmd write",       0, 3'd7, 1, 0, 16'hA5C3, 2, 3, 0);
        access("R3 R8 narrow cmd read",        0, 3'd7, 0, 0, 16'h0000, 1, 1, 0);
        access("R10 R11 wide data write",      0, 3'd0, 1, 1, 16'hBEEF, 3, 4, 0);
        access("R10 R11 wide data read",       0, 3'd0, 0, 1, 16'h0000, 2, 2, 0);
        access("R10 wide flag on addr1 read",  0, 3'd1, 0, 1, 16'h0000, 1, 2, 0);
        access("R10 R8 wide flag ctrl write",  1, 3'd0, 1, 1, 16'h1234, 1, 1, 0);
        access("R5 R6 zero counts ctrl read",  1, 3'd6, 0, 0, 16'h0000, 0, 0, 0);
        access("R5 R6 max counts read",        0, 3'd2, 0, 0, 16'h0000, 15, 15, 0);
        access("R7 R2 disturbed write",        0, 3'd0, 1, 1, 16'hC0DE, 4, 5, 1);
        access("R7 R2 disturbed read",         1, 3'd7, 0, 0, 16'h0000, 3, 3, 1);
        access("R9 back to back read",         0, 3'd4, 0, 0, 16'h0000, 1, 3, 0);
        access("R9 back to back read",         0, 3'd5, 0, 0, 16'h0000, 2, 1, 0);
        access("R12 final wide read",          0, 3'd0, 0, 1, 16'h0000, 1, 1, 0);
        scen = "R1 drain";
        repeat (30) step(idle);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 expired");
        summary();
    end
endmodule